// File: doc/BRIEF.md
# Gated Fractional Clock-Enable Generator

This block produces a stream of single-cycle clock-enable pulses whose average rate is the input clock rate scaled by a ratio M/N. A peripheral such as a UART uses the pulses as its baud reference. For example, with a 120 MHz input, M=192 and N=12500 give 1,843,200 pulses per second. A single 32-bit control word sets the block up: a gate enable, a staged numerator, a staged denominator and a self-clearing update strobe. A new ratio reaches the divider only when software writes the strobe, so software can rewrite the fields freely without disturbing the running rate.

The divider is an accumulator. On every input cycle it adds the active M. Whenever the sum reaches or exceeds the active N, it subtracts N and emits one pulse. Over any N consecutive running cycles that start from a cleared accumulator, exactly M pulses appear.

Top module: `frac_clk_gate`

## Requirements
- R1: After reset, rd_data reads 0 and clk_en_o is 0. The block stays idle until software writes the control word.
- R2: A write stores bit 0 as the enable, bits 15:1 as staged M and bits 30:16 as staged N. From the next cycle, rd_data returns these fields in the same positions, and bit 31 always reads 0.
- R3: A write with bit 31 at 0 leaves the active M and N unchanged, so the pulse pattern continues as before.
- R4: A write with bit 31 at 1 loads the written M and N into the active divider and clears the accumulator. clk_en_o is 0 in the cycle after that write.
- R5: While the enable bit reads 0, clk_en_o is 0 and the accumulator holds its value.
- R6: If the active M is 0, the active N is 0, or M is greater than N, clk_en_o stays 0.
- R7: With M equal to N and the gate enabled, clk_en_o is 1 on every cycle after the first cycle following the update.
- R8: With M=192 and N=12500, exactly 192 pulses appear in the 12500 cycles that follow the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Readback of enable and staged M, N (bit 31 reads 0) |
| clk_en_o | output | 1 | Gated fractional clock-enable pulse |

## Verification
A write takes effect at the next clock edge. From the cycle after that edge, rd_data shows the new fields and the gate applies. After an update, the first add happens one edge later, so the first possible pulse is visible two cycles after the write. The bench drives inputs and compares outputs on the falling edge. A behavioural model advances on each rising edge, so every comparison lines up with these latencies. The rate requirements are checked by counting pulses over exactly N cycles that start right after the update cycle.

// File: rtl/frac_clk_gate.sv
module frac_clk_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        clk_en_o
);
  logic        gate_en;
  logic [14:0] m_stage, n_stage, m_act, n_act;
  logic [15:0] acc;
  logic        pulse;

  wire [15:0] sum    = acc + {1'b0, m_act};
  wire [15:0] n_wide = {1'b0, n_act};
  wire        cfg_ok = (m_act != 15'd0) && (n_act != 15'd0) && (m_act <= n_act);
  wire        run    = gate_en && cfg_ok;
  wire        load   = wr_en && wr_data[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en <= 1'b0;
      m_stage <= '0;
      n_stage <= '0;
      m_act   <= '0;
      n_act   <= '0;
      acc     <= '0;
      pulse   <= 1'b0;
    end else begin
      if (wr_en) begin
        gate_en <= wr_data[0];
        m_stage <= wr_data[15:1];
        n_stage <= wr_data[30:16];
      end
      if (load) begin
        m_act <= wr_data[15:1];
        n_act <= wr_data[30:16];
        acc   <= '0;
        pulse <= 1'b0;
      end else if (run) begin
        if (sum >= n_wide) begin
          acc   <= sum - n_wide;
          pulse <= 1'b1;
        end else begin
          acc   <= sum;
          pulse <= 1'b0;
        end
      end else begin
        pulse <= 1'b0;
      end
    end
  end

  assign rd_data  = {1'b0, n_stage, m_stage, gate_en};
  assign clk_en_o = pulse & gate_en;
endmodule

// File: rtl/frac_clk_gate_chk.sv
module frac_clk_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        clk_en_o,
  input logic [14:0] m_act,
  input logic [14:0] n_act
);
  assert_rd_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == 1'b0);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[30:0] == $past(wr_data[30:0]));

  assert_update_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31]) |=> !clk_en_o);

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> !clk_en_o);

  assert_bad_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act == 15'd0 || n_act == 15'd0 || m_act > n_act) |=> !clk_en_o);

  assert_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[31]) |=> $stable(m_act) && $stable(n_act));
endmodule

bind frac_clk_gate frac_clk_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .clk_en_o(clk_en_o), .m_act(m_act), .n_act(n_act)
);

// File: tb/tb_frac_clk_gate.sv
module tb_frac_clk_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_en_o;

  int tests = 0, fails = 0, cycles = 0;
  string req = "R1";

  int m_en = 0, m_ms = 0, m_ns = 0, m_am = 0, m_an = 0, m_acc = 0, m_pulse = 0;

  frac_clk_gate dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                     .rd_data(rd_data), .clk_en_o(clk_en_o));

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ms = 0; m_ns = 0; m_am = 0; m_an = 0; m_acc = 0; m_pulse = 0;
    end else begin
      int wm, wn;
      wm = int'(wr_data[15:1]);
      wn = int'(wr_data[30:16]);
      if (wr_en && wr_data[31]) begin
        m_am = wm; m_an = wn; m_acc = 0; m_pulse = 0;
      end else if (m_en == 1 && m_am > 0 && m_an > 0 && m_am <= m_an) begin
        m_acc = m_acc + m_am;
        if (m_acc >= m_an) begin m_acc = m_acc - m_an; m_pulse = 1; end
        else m_pulse = 0;
      end else m_pulse = 0;
      if (wr_en) begin m_en = int'(wr_data[0]); m_ms = wm; m_ns = wn; end
    end
  end

  function automatic logic [31:0] exp_rd();
    return {1'b0, m_ns[14:0], m_ms[14:0], m_en[0]};
  endfunction

  always @(negedge clk) begin
    cycles++;
    tests++;
    if (clk_en_o !== ((m_pulse == 1 && m_en == 1) ? 1'b1 : 1'b0)) begin
      fails++;
      $display("FAIL %s clk_en_o actual %0b expected %0b", req, clk_en_o, (m_pulse & m_en));
    end
    tests++;
    if (rd_data !== exp_rd()) begin
      fails++;
      $display("FAIL %s rd_data actual %h expected %h", req, rd_data, exp_rd());
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [31:0] word(int en, int m, int n, int upd);
    return {upd[0], n[14:0], m[14:0], en[0]};
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count(int ncyc, int expect_n, string r);
    int c = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      #1;
      if (clk_en_o) c++;
    end
    tests++;
    if (c != expect_n) begin
      fails++;
      $display("FAIL %s pulse count actual %0d expected %0d", r, c, expect_n);
    end
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req = "R2"; wr(word(0, 100, 200, 0)); repeat (2) @(negedge clk);
    req = "R6"; wr(word(1, 0, 10, 1)); repeat (10) @(negedge clk);
    wr(word(1, 5, 0, 1)); repeat (10) @(negedge clk);
    wr(word(1, 9, 4, 1)); count(20, 0, "R6");
    req = "R7"; wr(word(1, 5, 5, 1)); @(negedge clk); count(20, 20, "R7");
    req = "R4"; wr(word(1, 1, 4, 1)); count(40, 10, "R4");
    req = "R3"; wr(word(1, 3, 4, 0)); count(40, 10, "R3");
    req = "R5"; wr(word(0, 1, 4, 0)); count(30, 0, "R5");
    wr(word(1, 1, 4, 0)); repeat (12) @(negedge clk);
    req = "R8"; wr(word(1, 192, 12500, 1)); count(12500, 192, "R8");
    req = "R4"; wr(word(1, 3, 7, 1)); repeat (50) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule